// File: doc/BRIEF.md
# SD Card Data Block Receiver

This block pulls one data block from an SD card over either the single DAT0 line or all four DAT lines. A one-cycle `go` pulse latches the bus width and the block length. The block then drives the SD clock at half the system clock rate and watches the data lines for the start bit. It turns the card's bit stream into bytes, most significant part first, and presents each byte for one cycle on a byte stream output.

After the payload, each active line carries its own 16-bit CRC and then an end bit. The block keeps a running CRC for each line, covering only the bits that arrived on that line, and compares it with the received value. It checks the end bit on every active line. It then gives the card eight more SD clocks. Finally it pulses `done` and holds `crc_ok` and `timeout` until the next `go`. If the start bit does not arrive within a bounded number of SD clocks, the block ends at once with `timeout` set.

Top module: `sd_blk_rx`

## Requirements
- R1: After reset `sd_clk`, `byte_valid`, `done`, `crc_ok` and `timeout` are 0. While idle `sd_clk` stays low. Once `go` is taken, `sd_clk` toggles every system clock, and the data lines are sampled once per SD clock period, at the end of each high phase. `done` arrives 2·N+1 cycles after the `go` cycle, where N is the number of SD clock periods used.
- R2: When `wide`=0, the start bit is a sample with DAT0=0. All data is taken from DAT0 only, and `dat_in[3:1]` has no effect on bytes or on the result.
- R3: When `wide`=1, the start bit is a sample with all four lines at 0. A sample in which only some lines are 0 is treated as idle.
- R4: If no start bit has been seen after TMO_SAMPLES samples (default 5000), `done` pulses with `timeout`=1 and `crc_ok`=0, no byte is produced, and no trailing clocks are issued.
- R5: In 1-bit mode each byte is eight consecutive DAT0 samples, first sample in bit 7. The byte appears on `byte_data` with `byte_valid` high for one cycle.
- R6: In 4-bit mode each byte is two consecutive samples, the first nibble in bits 7:4. `dat_in[k]` maps to bit k of the nibble.
- R7: Each active line's CRC is x^16+x^12+x^5+1 with a zero seed, computed bit by bit over that line's payload bits. The 16 received CRC bits follow the payload, MSB first, on each line. Any mismatch on an active line gives `crc_ok`=0.
- R8: The sample after the CRC must be 1 on every active line, otherwise `crc_ok`=0.
- R9: After the end bit, exactly 8 more SD clock periods are issued. Then `done` is a one-cycle pulse, and `crc_ok` and `timeout` hold until the next `go`.
- R10: `blk_bytes` sets the block length in bytes (1 to 2^LEN_W−1), which includes the usual 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start one block transfer (taken while idle) |
| wide | input | 1 | 1 = four data lines, 0 = DAT0 only |
| blk_bytes | input | LEN_W | Block length in bytes |
| dat_in | input | 4 | Card data lines DAT[3:0] |
| sd_clk | output | 1 | Clock driven to the card |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Assembled byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| crc_ok | output | 1 | CRC and end bits correct on all active lines |
| timeout | output | 1 | Start bit never arrived |

## Verification
On every cycle the assertions check that:
- the SD clock keeps toggling while a transfer is active;
- bytes appear only right after a data sample and only during the payload or CRC phases;
- `done` is a single-cycle pulse and a timeout never comes with a pass;
- the start wait stays within its bound;
- each CRC lane starts from zero.

Only the bench's scenarios can show that byte values and nibble order are correct, that per-lane CRC and end-bit errors are caught, that a partial 4-bit start is rejected, and that exactly eight trailing clocks are issued. Its card model and CRC are written independently of the RTL.

// File: rtl/sd_rx_pkg.sv
package sd_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_END,
    ST_TRAIL
  } rx_state_t;

  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam int          CRC_BITS   = 16;
  localparam int          TRAIL_CLKS = 8;
  localparam int          NLANE      = 4;
endpackage

// File: rtl/sd_crc16_lane.sv
module sd_crc16_lane #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic upd,
  input  logic cap,
  input  logic din,
  output logic match
);
  logic [15:0] crc_calc;
  logic [15:0] crc_rx;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_calc <= '0;
      crc_rx   <= '0;
    end else begin
      if (upd)
        crc_calc <= {crc_calc[14:0], 1'b0} ^ ((crc_calc[15] ^ din) ? POLY : 16'h0000);
      if (cap)
        crc_rx <= {crc_rx[14:0], din};
    end
  end

  assign match = (crc_calc == crc_rx);

  // R7: a new transfer starts every lane from a zero seed
  p_zero_seed_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_calc == 16'h0000));
endmodule

// File: rtl/sd_rx_deser.sv
module sd_rx_deser (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       wide,
  input  logic [3:0] dat,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  logic [6:0] sh;
  logic [2:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh         <= '0;
      cnt        <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (en) begin
        if (wide) begin
          if (cnt[0]) begin
            byte_data  <= {sh[3:0], dat};
            byte_valid <= 1'b1;
            cnt        <= '0;
          end else begin
            sh  <= {3'b000, dat};
            cnt <= 3'd1;
          end
        end else begin
          if (cnt == 3'd7) begin
            byte_data  <= {sh, dat[0]};
            byte_valid <= 1'b1;
            cnt        <= '0;
          end else begin
            sh  <= {sh[5:0], dat[0]};
            cnt <= cnt + 3'd1;
          end
        end
      end
    end
  end

  // R5 / R6: a byte is only ever emitted right after a data sample
  p_byte_after_sample_r5: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(en));
endmodule

// File: rtl/sd_blk_rx.sv
module sd_blk_rx
  import sd_rx_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int TMO_SAMPLES = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             wide,
  input  logic [LEN_W-1:0] blk_bytes,
  input  logic [3:0]       dat_in,
  output logic             sd_clk,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             done,
  output logic             crc_ok,
  output logic             timeout
);
  localparam int TMO_W  = $clog2(TMO_SAMPLES + 1);
  localparam int SCNT_W = LEN_W + 3;

  rx_state_t         st;
  logic              wide_q;
  logic [LEN_W-1:0]  len_q;
  logic [TMO_W-1:0]  wait_cnt;
  logic [SCNT_W-1:0] scnt;
  logic [SCNT_W-1:0] slast;
  logic              samp;
  logic              seq_clr;
  logic              start_seen;
  logic              end_ok;
  logic              lanes_ok;
  logic              pass_q;
  logic [NLANE-1:0]  lane_en;
  logic [NLANE-1:0]  match;

  assign samp    = (st != ST_IDLE) && sd_clk;
  assign seq_clr = (st == ST_IDLE) && go;

  always_comb begin
    slast      = (wide_q ? {2'b00, len_q, 1'b0} : {len_q, 3'b000}) - SCNT_W'(1);
    start_seen = wide_q ? (dat_in == 4'h0) : !dat_in[0];
    end_ok     = wide_q ? (dat_in == 4'hF) : dat_in[0];
    lanes_ok   = wide_q ? (&match) : match[0];
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_en[g] = (g == 0) || wide_q;
    sd_crc16_lane #(.POLY(CRC_POLY)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .clr   (seq_clr),
      .upd   (samp && (st == ST_DATA) && lane_en[g]),
      .cap   (samp && (st == ST_CRC)),
      .din   (dat_in[g]),
      .match (match[g])
    );
  end

  sd_rx_deser u_deser (
    .clk        (clk),
    .rst        (rst),
    .clr        (seq_clr),
    .en         (samp && (st == ST_DATA)),
    .wide       (wide_q),
    .dat        (dat_in),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      sd_clk   <= 1'b0;
      done     <= 1'b0;
      crc_ok   <= 1'b0;
      timeout  <= 1'b0;
      wide_q   <= 1'b0;
      len_q    <= '0;
      wait_cnt <= '0;
      scnt     <= '0;
      pass_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        sd_clk <= 1'b0;
        if (go) begin
          st       <= ST_WAIT;
          wide_q   <= wide;
          len_q    <= blk_bytes;
          wait_cnt <= '0;
          scnt     <= '0;
          crc_ok   <= 1'b0;
          timeout  <= 1'b0;
        end
      end else begin
        sd_clk <= ~sd_clk;
        if (samp) begin
          case (st)
            ST_WAIT: begin
              if (start_seen) begin
                st   <= ST_DATA;
                scnt <= '0;
              end else if (wait_cnt == TMO_W'(TMO_SAMPLES - 1)) begin
                st      <= ST_IDLE;
                sd_clk  <= 1'b0;
                done    <= 1'b1;
                timeout <= 1'b1;
              end else begin
                wait_cnt <= wait_cnt + TMO_W'(1);
              end
            end
            ST_DATA: begin
              if (scnt == slast) begin
                st   <= ST_CRC;
                scnt <= '0;
              end else begin
                scnt <= scnt + SCNT_W'(1);
              end
            end
            ST_CRC: begin
              if (scnt == SCNT_W'(CRC_BITS - 1)) begin
                st   <= ST_END;
                scnt <= '0;
              end else begin
                scnt <= scnt + SCNT_W'(1);
              end
            end
            ST_END: begin
              pass_q <= end_ok && lanes_ok;
              st     <= ST_TRAIL;
              scnt   <= '0;
            end
            ST_TRAIL: begin
              if (scnt == SCNT_W'(TRAIL_CLKS - 1)) begin
                st     <= ST_IDLE;
                sd_clk <= 1'b0;
                done   <= 1'b1;
                crc_ok <= pass_q;
              end else begin
                scnt <= scnt + SCNT_W'(1);
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R1: the card clock keeps toggling while a transfer is active
  p_clk_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> ((st == ST_IDLE) || (sd_clk != $past(sd_clk))));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: a timed-out transfer never reports a pass
  p_tmo_no_pass_r4: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !crc_ok);

  // R4: the start wait never runs past its bound
  p_wait_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> (wait_cnt < TMO_W'(TMO_SAMPLES)));

  // R5: bytes only appear during or just after the payload phase
  p_byte_phase_r5: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> ((st == ST_DATA) || (st == ST_CRC)));
endmodule

// File: tb/sd_blk_rx_test.sv
module sd_blk_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 12;
  localparam int TMO        = 5000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             go = 1'b0;
  logic             wide = 1'b0;
  logic [LEN_W-1:0] blk_bytes = '0;
  logic [3:0]       dat_in = 4'hF;
  logic             sd_clk, byte_valid, done, crc_ok, timeout;
  logic [7:0]       byte_data;

  int checks = 0;
  int fails  = 0;
  int pops   = 0;
  logic [3:0] sq[$];
  logic [7:0] eq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_blk_rx #(.LEN_W(LEN_W), .TMO_SAMPLES(TMO)) uut (
    .clk(clk), .rst(rst), .go(go), .wide(wide), .blk_bytes(blk_bytes),
    .dat_in(dat_in), .sd_clk(sd_clk), .byte_valid(byte_valid),
    .byte_data(byte_data), .done(done), .crc_ok(crc_ok), .timeout(timeout));

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  // card model: presents one sample per SD clock high phase; byte stream compare
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) begin
        if (eq.size() == 0) begin
          chk(1'b0, "R5/R6", "unexpected byte", int'(byte_data), -1);
        end else begin
          logic [7:0] e;
          e = eq.pop_front();
          chk(byte_data === e, wide ? "R6" : "R5", "byte value", int'(byte_data), int'(e));
        end
      end
      if (sd_clk) begin
        dat_in = (sq.size() != 0) ? sq.pop_front() : 4'hF;
        pops++;
      end
    end
  end

  task automatic start_and_wait(input bit wd, input int len, output int cyc, output bit seen);
    @(negedge clk);
    wide = wd;
    blk_bytes = LEN_W'(len);
    pops = 0;
    go = 1'b1;
    cyc = 0;
    seen = 1'b0;
    while (!seen && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) go = 1'b0;
      if (done) seen = 1'b1;
    end
    if (!seen) chk(1'b0, "R9", "watchdog expired", cyc, -1);
  endtask

  task automatic run_block(input bit wd, input int len, input int pre, input int bad_lane,
                           input bit bad_end, input bit junk, input bit partial, input string req);
    logic [15:0] lc[4];
    logic [31:0] r;
    logic [3:0]  v;
    int exp_pops, cyc;
    bit seen, exp_ok;
    sq.delete();
    eq.delete();
    for (int l = 0; l < 4; l++) lc[l] = 16'h0000;
    for (int i = 0; i < pre; i++) begin
      r = $urandom();
      if (wd) v = partial ? {r[0], 3'b000} | 4'b1000 : 4'hF;
      else    v = junk ? {r[2:0], 1'b1} : 4'hF;
      sq.push_back(v);
    end
    r = $urandom();
    sq.push_back(wd ? 4'h0 : (junk ? {r[2:0], 1'b0} : 4'hE));
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom());
      eq.push_back(b);
      if (wd) begin
        for (int h = 0; h < 2; h++) begin
          v = (h == 0) ? b[7:4] : b[3:0];
          sq.push_back(v);
          for (int l = 0; l < 4; l++) lc[l] = crc_step(lc[l], v[l]);
        end
      end else begin
        for (int k = 7; k >= 0; k--) begin
          r = $urandom();
          sq.push_back({junk ? r[2:0] : 3'b111, b[k]});
          lc[0] = crc_step(lc[0], b[k]);
        end
      end
    end
    if (bad_lane >= 0) lc[bad_lane] = lc[bad_lane] ^ 16'h0400;
    for (int i = 15; i >= 0; i--) begin
      r = $urandom();
      if (wd) sq.push_back({lc[3][i], lc[2][i], lc[1][i], lc[0][i]});
      else    sq.push_back({junk ? r[2:0] : 3'b111, lc[0][i]});
    end
    if (wd) sq.push_back(bad_end ? 4'b1101 : 4'hF);
    else    sq.push_back({3'b111, ~bad_end});
    exp_ok   = (bad_lane < 0) && !bad_end;
    exp_pops = pre + 1 + len * (wd ? 2 : 8) + 16 + 1 + 8;
    start_and_wait(wd, len, cyc, seen);
    if (seen) begin
      chk(crc_ok == exp_ok, req, "crc_ok", int'(crc_ok), int'(exp_ok));
      chk(timeout == 1'b0, "R4", "timeout on good start", int'(timeout), 0);
      chk(pops == exp_pops, "R9", "SD clock periods incl. 8 trailing", pops, exp_pops);
      chk(cyc == 2 * exp_pops + 1, "R1", "cycles go to done", cyc, 2 * exp_pops + 1);
      chk(eq.size() == 0, "R10", "bytes missing", eq.size(), 0);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done pulse width", int'(done), 0);
      chk(crc_ok == exp_ok, "R9", "crc_ok held", int'(crc_ok), int'(exp_ok));
      chk(sd_clk == 1'b0, "R1", "sd_clk idle low", int'(sd_clk), 0);
    end
  endtask

  initial begin
    int cyc;
    bit seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sd_clk == 1'b0 && byte_valid == 1'b0, "R1", "reset clk/byte", int'(sd_clk), 0);
    chk(done == 1'b0 && crc_ok == 1'b0 && timeout == 1'b0, "R1", "reset flags", int'(done), 0);

    run_block(1'b0, 4,   3, -1, 1'b0, 1'b0, 1'b0, "R2");   // 1-bit good
    run_block(1'b0, 4,   2, -1, 1'b0, 1'b1, 1'b0, "R2");   // 1-bit, upper lanes noisy
    run_block(1'b1, 8,   4, -1, 1'b0, 1'b0, 1'b0, "R6");   // 4-bit good
    run_block(1'b1, 8,   5, -1, 1'b0, 1'b0, 1'b1, "R3");   // 4-bit partial start ignored
    run_block(1'b1, 8,   2,  2, 1'b0, 1'b0, 1'b0, "R7");   // lane 2 CRC corrupted
    run_block(1'b0, 6,   1,  0, 1'b0, 1'b0, 1'b0, "R7");   // 1-bit CRC corrupted
    run_block(1'b1, 5,   1, -1, 1'b1, 1'b0, 1'b0, "R8");   // 4-bit end bit low on lane 1
    run_block(1'b0, 5,   1, -1, 1'b1, 1'b0, 1'b0, "R8");   // 1-bit end bit low
    run_block(1'b0, 512, 7, -1, 1'b0, 1'b0, 1'b0, "R10");  // full 512-byte block

    // R4: card never answers
    sq.delete();
    eq.delete();
    start_and_wait(1'b0, 4, cyc, seen);
    if (seen) begin
      chk(timeout == 1'b1, "R4", "timeout flag", int'(timeout), 1);
      chk(crc_ok == 1'b0, "R4", "crc_ok on timeout", int'(crc_ok), 0);
      chk(pops == TMO, "R4", "samples before timeout", pops, TMO);
      chk(cyc == 2 * TMO + 1, "R4", "cycles to timeout", cyc, 2 * TMO + 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule